// File: doc/BRIEF.md
# Interrupt Level Mask Arbiter

This block decides, cycle by cycle, whether the processor takes an interrupt. Sixteen request lines each carry a 3-bit priority level that software programs per source. Level 0 is the most urgent and level 7 the least. A 3-bit mask register holds the level of the interrupt now in service. A pending request can pass only when the global interrupt enable is set and its level is numerically below the mask.

When several enabled requests are pending, the one with the smallest level is picked, and among equal levels the lowest source number wins. If that winner passes the mask, the block raises a one-cycle accept strobe. The winner's index and level are valid in the same cycle. The mask then takes the accepted level at the next clock edge, which shuts out every request of equal or lower urgency until the mask changes again.

Software may load the mask with an 8-bit write. On return from an interrupt, a restore input reloads the saved mask level. The mask is also presented inside a 16-bit status word.

Top module: `ilm_arbiter`

## Requirements
- R1: Reset sets the mask to 0 and every per-source level to 7. The accept output is 0 while the mask is 0, so no request is accepted after reset until the mask is raised.
- R2: accept is 1 only when int_en is 1, at least one irq_req bit is 1, and the winning level is strictly less than mask_lvl. With int_en at 0, accept stays 0.
- R3: The winner is the pending request with the numerically smallest level. Among requests with that level, the lowest source index wins.
- R4: accept is a combinational output in the cycle the request condition holds. accept_idx and accept_lvl give the winner's source index and level in that same cycle.
- R5: After a cycle with accept at 1 and restore_en at 0, mask_lvl equals the accepted level from the next clock edge on. A request that stays asserted at that level is then no longer accepted.
- R6: When mask_wr_en is 1, and neither restore nor accept happens in that cycle, mask_lvl takes mask_wr_data[2:0] at the next edge. Bits 7 to 3 of the write data are ignored.
- R7: restore_en loads restore_lvl into the mask at the next edge. This overrides an acceptance and a software write in the same cycle.
- R8: An acceptance in the same cycle as a software mask write wins over the write.
- R9: A source whose level is 7 is never accepted.
- R10: status_word carries mask_lvl in bits 15 to 13, with all other bits 0.
- R11: A level write (lvl_wr_en, lvl_wr_idx, lvl_wr_data) changes only the addressed source's level, from the next clock edge on. In the cycle of the write, arbitration uses the old level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| int_en | input | 1 | Global interrupt enable |
| irq_req | input | 16 | Request lines, one per source |
| lvl_wr_en | input | 1 | Per-source level write strobe |
| lvl_wr_idx | input | 4 | Source addressed by the level write |
| lvl_wr_data | input | 3 | New level for the addressed source |
| mask_wr_en | input | 1 | Software mask write strobe |
| mask_wr_data | input | 8 | Software mask write data; only the low 3 bits are kept |
| restore_en | input | 1 | Mask restore on interrupt return |
| restore_lvl | input | 3 | Level restored into the mask |
| accept | output | 1 | One-cycle accept strobe |
| accept_idx | output | 4 | Index of the accepted source |
| accept_lvl | output | 3 | Level of the accepted source |
| mask_lvl | output | 3 | Current mask level |
| status_word | output | 16 | Status word with the mask in bits 15 to 13 |

## Verification
The accept strobe, index and level are combinational. They are due in the same cycle the inputs are applied. The mask, the status word and the per-source levels change one rising edge after a write, a restore or an acceptance.

The bench drives inputs at the falling edge and samples the combinational outputs 1 ns later, comparing them against a reference model. It advances that model only at the following rising edge, so every registered result is compared in the cycle after its cause. Random traffic is mixed with directed cases for ties, level 7, the disabled case and the update-priority collisions.

// File: rtl/ilm_pkg.sv
package ilm_pkg;

  localparam int unsigned LVL_W   = 3;
  localparam int unsigned LVL_MAX = (1 << LVL_W) - 1;

  typedef logic [LVL_W-1:0] lvl_t;

  // Request passes when enabled and strictly more urgent than the mask
  function automatic logic lvl_passes(input logic en, input lvl_t lvl, input lvl_t mask);
    return en && (lvl < mask);
  endfunction

  // Candidate replaces incumbent only when strictly more urgent
  function automatic logic lvl_beats(input lvl_t cand, input lvl_t best);
    return cand < best;
  endfunction

endpackage

// File: rtl/ilm_level_bank.sv
module ilm_level_bank
  import ilm_pkg::*;
#(
  parameter int unsigned N_SRC = 16,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  lvl_t                   wr_data,
  output logic [N_SRC*LVL_W-1:0] lvl_flat
);

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    lvl_t lvl_q;
    logic hit;

    assign hit = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_q <= lvl_t'(LVL_MAX);
      end else if (hit) begin
        lvl_q <= wr_data;
      end
    end

    assign lvl_flat[g*LVL_W +: LVL_W] = lvl_q;
  end

endmodule

// File: rtl/ilm_pri_select.sv
module ilm_pri_select
  import ilm_pkg::*;
#(
  parameter int unsigned N_SRC = 16,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]       req,
  input  logic [N_SRC*LVL_W-1:0] lvl_flat,
  output logic                   found,
  output logic [IDX_W-1:0]       win_idx,
  output lvl_t                   win_lvl
);

  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = lvl_t'(LVL_MAX);
    for (int i = 0; i < N_SRC; i++) begin
      if (req[i] && (!found || lvl_beats(lvl_flat[i*LVL_W +: LVL_W], win_lvl))) begin
        found   = 1'b1;
        win_idx = IDX_W'(i);
        win_lvl = lvl_flat[i*LVL_W +: LVL_W];
      end
    end
  end

endmodule

// File: rtl/ilm_mask_reg.sv
module ilm_mask_reg
  import ilm_pkg::*;
#(
  parameter int unsigned WDATA_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restore_en,
  input  lvl_t               restore_lvl,
  input  logic               acc_en,
  input  lvl_t               acc_lvl,
  input  logic               wr_en,
  input  logic [WDATA_W-1:0] wr_data,
  output lvl_t               mask
);

  lvl_t mask_d;
  logic unused_wr_hi;

  assign unused_wr_hi = ^wr_data[WDATA_W-1:LVL_W];

  // Update priority: restore, then acceptance, then software write
  always_comb begin
    mask_d = mask;
    if (restore_en) begin
      mask_d = restore_lvl;
    end else if (acc_en) begin
      mask_d = acc_lvl;
    end else if (wr_en) begin
      mask_d = wr_data[LVL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
    end else begin
      mask <= mask_d;
    end
  end

endmodule

// File: rtl/ilm_arbiter.sv
module ilm_arbiter
  import ilm_pkg::*;
#(
  parameter int unsigned N_SRC    = 16,
  parameter int unsigned WDATA_W  = 8,
  parameter int unsigned PS_W     = 16,
  parameter int unsigned MASK_LSB = 13,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               int_en,
  input  logic [N_SRC-1:0]   irq_req,
  input  logic               lvl_wr_en,
  input  logic [IDX_W-1:0]   lvl_wr_idx,
  input  logic [LVL_W-1:0]   lvl_wr_data,
  input  logic               mask_wr_en,
  input  logic [WDATA_W-1:0] mask_wr_data,
  input  logic               restore_en,
  input  logic [LVL_W-1:0]   restore_lvl,
  output logic               accept,
  output logic [IDX_W-1:0]   accept_idx,
  output logic [LVL_W-1:0]   accept_lvl,
  output logic [LVL_W-1:0]   mask_lvl,
  output logic [PS_W-1:0]    status_word
);

  logic [N_SRC*LVL_W-1:0] lvl_flat;
  logic                   win_found;
  logic [IDX_W-1:0]       win_idx;
  lvl_t                   win_lvl;
  logic                   take_evt;   // acceptance event
  lvl_t                   mask_q;

  ilm_level_bank #(.N_SRC(N_SRC)) u_levels (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (lvl_wr_en),
    .wr_idx   (lvl_wr_idx),
    .wr_data  (lvl_wr_data),
    .lvl_flat (lvl_flat)
  );

  ilm_pri_select #(.N_SRC(N_SRC)) u_select (
    .req      (irq_req),
    .lvl_flat (lvl_flat),
    .found    (win_found),
    .win_idx  (win_idx),
    .win_lvl  (win_lvl)
  );

  assign take_evt = win_found && lvl_passes(int_en, win_lvl, mask_q);

  ilm_mask_reg #(.WDATA_W(WDATA_W)) u_mask (
    .clk         (clk),
    .rst_n       (rst_n),
    .restore_en  (restore_en),
    .restore_lvl (restore_lvl),
    .acc_en      (take_evt),
    .acc_lvl     (win_lvl),
    .wr_en       (mask_wr_en),
    .wr_data     (mask_wr_data),
    .mask        (mask_q)
  );

  assign accept      = take_evt;
  assign accept_idx  = take_evt ? win_idx : '0;
  assign accept_lvl  = take_evt ? win_lvl : '0;
  assign mask_lvl    = mask_q;
  assign status_word = PS_W'({{(PS_W-LVL_W){1'b0}}, mask_q} << MASK_LSB);

endmodule

// File: rtl/ilm_arbiter_checker.sv
module ilm_arbiter_checker #(
  parameter int unsigned N_SRC = 16,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned LVL_W = 3,
  parameter int unsigned WDATA_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               int_en,
  input logic [N_SRC-1:0]   irq_req,
  input logic               mask_wr_en,
  input logic [WDATA_W-1:0] mask_wr_data,
  input logic               restore_en,
  input logic [LVL_W-1:0]   restore_lvl,
  input logic               accept,
  input logic [IDX_W-1:0]   accept_idx,
  input logic [LVL_W-1:0]   accept_lvl,
  input logic [LVL_W-1:0]   mask_lvl
);

  a_r1_closed_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_lvl == '0) |-> !accept);

  a_r2_gate: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (int_en && (accept_lvl < mask_lvl)));

  a_r4_idx_pending: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> irq_req[accept_idx]);

  a_r5_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !restore_en) |=> (mask_lvl == $past(accept_lvl)));

  a_r6_sw_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr_en && !restore_en && !accept) |=> (mask_lvl == $past(mask_wr_data[LVL_W-1:0])));

  a_r7_restore: assert property (@(posedge clk) disable iff (!rst_n)
    restore_en |=> (mask_lvl == $past(restore_lvl)));

  a_r9_never_seven: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (accept_lvl != '1));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !restore_en && !mask_wr_en) |=> $stable(mask_lvl));

endmodule

bind ilm_arbiter ilm_arbiter_checker #(
  .N_SRC(N_SRC), .IDX_W(IDX_W), .LVL_W(ilm_pkg::LVL_W), .WDATA_W(WDATA_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .int_en       (int_en),
  .irq_req      (irq_req),
  .mask_wr_en   (mask_wr_en),
  .mask_wr_data (mask_wr_data),
  .restore_en   (restore_en),
  .restore_lvl  (restore_lvl),
  .accept       (accept),
  .accept_idx   (accept_idx),
  .accept_lvl   (accept_lvl),
  .mask_lvl     (mask_lvl)
);

// File: tb/test_ilm_arbiter.sv
module test_ilm_arbiter;
  localparam int N  = 16;
  localparam int IW = 4;
  localparam int LW = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          int_en;
  logic [N-1:0]  irq_req;
  logic          lvl_wr_en;
  logic [IW-1:0] lvl_wr_idx;
  logic [LW-1:0] lvl_wr_data;
  logic          mask_wr_en;
  logic [7:0]    mask_wr_data;
  logic          restore_en;
  logic [LW-1:0] restore_lvl;
  wire           accept;
  wire  [IW-1:0] accept_idx;
  wire  [LW-1:0] accept_lvl;
  wire  [LW-1:0] mask_lvl;
  wire  [15:0]   status_word;

  ilm_arbiter i_ilm_arbiter (
    .clk(clk), .rst_n(rst_n), .int_en(int_en), .irq_req(irq_req),
    .lvl_wr_en(lvl_wr_en), .lvl_wr_idx(lvl_wr_idx), .lvl_wr_data(lvl_wr_data),
    .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
    .restore_en(restore_en), .restore_lvl(restore_lvl),
    .accept(accept), .accept_idx(accept_idx), .accept_lvl(accept_lvl),
    .mask_lvl(mask_lvl), .status_word(status_word)
  );

  int checks = 0;
  int errors = 0;
  logic [LW-1:0] m_lvl [N];
  logic [LW-1:0] m_mask;
  logic done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference pick: scan levels from most urgent, then sources in order
  function automatic logic [IW+LW:0] ref_pick();
    for (int l = 0; l < 8; l++)
      for (int s = 0; s < N; s++)
        if (irq_req[s] && m_lvl[s] == LW'(l))
          return {1'b1, IW'(s), LW'(l)};
    return '0;
  endfunction

  task automatic model_reset();
    m_mask = '0;
    for (int s = 0; s < N; s++) m_lvl[s] = 3'd7;
  endtask

  task automatic idle();
    int_en = 1'b1; irq_req = '0; lvl_wr_en = 1'b0; lvl_wr_idx = '0; lvl_wr_data = '0;
    mask_wr_en = 1'b0; mask_wr_data = '0; restore_en = 1'b0; restore_lvl = '0;
  endtask

  // Called just after a falling edge with inputs set
  task automatic step(input string tag);
    logic [IW+LW:0] p;
    logic exp_acc;
    #1;
    p = ref_pick();
    exp_acc = rst_n && int_en && p[IW+LW] && (p[LW-1:0] < m_mask);
    chk({tag, " R2 R4 accept"}, 32'(accept), 32'(exp_acc));
    if (exp_acc) begin
      chk({tag, " R3 accept_idx"}, 32'(accept_idx), 32'(p[IW+LW-1:LW]));
      chk({tag, " R4 accept_lvl"}, 32'(accept_lvl), 32'(p[LW-1:0]));
    end
    chk({tag, " R5 mask_lvl"}, 32'(mask_lvl), 32'(m_mask));
    chk({tag, " R10 status_word"}, 32'(status_word), 32'({m_mask, 13'b0}));
    @(posedge clk);
    if (!rst_n) model_reset();
    else begin
      if (restore_en) m_mask = restore_lvl;
      else if (exp_acc) m_mask = p[LW-1:0];
      else if (mask_wr_en) m_mask = mask_wr_data[LW-1:0];
      if (lvl_wr_en) m_lvl[lvl_wr_idx] = lvl_wr_data;
    end
    @(negedge clk);
  endtask

  task automatic set_lvl(input int s, input int l);
    idle(); lvl_wr_en = 1'b1; lvl_wr_idx = IW'(s); lvl_wr_data = LW'(l);
    step("R11 level write");
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    idle();
    rst_n = 1'b0;
    @(negedge clk);
    // R1: reset state
    irq_req = '1;
    step("R1 in reset");
    step("R1 in reset");
    rst_n = 1'b1;
    // R1 R9: all levels 7 and mask 0 after reset
    step("R1 after reset");
    idle(); mask_wr_en = 1'b1; mask_wr_data = 8'hFF;
    step("R6 write 0xFF");
    idle(); irq_req = '1;
    step("R9 all level 7");
    // R6: upper data bits ignored, 0xFD -> 5
    idle(); mask_wr_en = 1'b1; mask_wr_data = 8'hFD;
    step("R6 write 0xFD");
    // R11: level write takes effect next edge, old level used in write cycle
    set_lvl(3, 2);
    set_lvl(9, 2);
    idle(); irq_req[1] = 1'b1; lvl_wr_en = 1'b1; lvl_wr_idx = 4'd1; lvl_wr_data = 3'd4;
    step("R11 same-cycle write");
    // R3: tie at level 2 resolved to index 3; R5 mask becomes 2
    idle(); irq_req[1] = 1'b1; irq_req[3] = 1'b1; irq_req[9] = 1'b1;
    step("R3 tie");
    step("R5 held request blocked");
    // R2: disabled
    idle(); mask_wr_en = 1'b1; mask_wr_data = 8'h07; step("R6 raise");
    idle(); int_en = 1'b0; irq_req = '1; step("R2 disabled");
    // R8: acceptance beats software write
    idle(); irq_req[1] = 1'b1; mask_wr_en = 1'b1; mask_wr_data = 8'h06;
    step("R8 accept vs write");
    // R7: restore beats acceptance
    idle(); restore_en = 1'b1; restore_lvl = 3'd6; step("R7 restore");
    idle(); irq_req[3] = 1'b1; restore_en = 1'b1; restore_lvl = 3'd5;
    mask_wr_en = 1'b1; mask_wr_data = 8'h01;
    step("R7 restore vs accept");
    // R9: level 7 source with mask 7
    idle(); mask_wr_en = 1'b1; mask_wr_data = 8'h07; step("R6 raise");
    idle(); irq_req[0] = 1'b1; step("R9 level 7 source");

    // Random traffic
    for (int c = 0; c < 4000; c++) begin
      idle();
      int_en     = ($urandom % 8) != 0;
      irq_req    = N'($urandom) & N'($urandom);
      lvl_wr_en  = ($urandom % 3) == 0;
      lvl_wr_idx = IW'($urandom);
      lvl_wr_data = LW'($urandom);
      mask_wr_en = ($urandom % 6) == 0;
      mask_wr_data = 8'($urandom);
      restore_en = ($urandom % 5) == 0;
      restore_lvl = LW'($urandom);
      step("random R2 R3");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule